// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that sits in front of a successive-approximation converter core. Software programs it through a small write/read register port. It sets an enable, a start request, a free-running mode, an interrupt enable, an input channel, a reference selection and a result alignment. The sequencer counts conversion steps on a clock-enable tick that a prescaler supplies elsewhere. It samples a 10-bit digital word that stands in for the converter core's output, stores that word as the result, then raises a completion flag and, optionally, an interrupt.

Channel and reference settings go to the analog side through the `chan_sel` and `ref_sel` outputs. A write to either setting while a conversion is running is held back and takes effect when that conversion completes. A change of reference makes the next conversion a long one, so the reference has time to settle. The alignment setting acts on the readable result at once.

Register map (address on `wr_addr`/`rd_addr`):
- Address 0, control: bit 0 enable, bit 1 start, bit 2 free-running, bit 3 completion flag (write 1 clears), bit 4 interrupt enable.
- Address 1, selection: bits 2:0 channel, bits 4:3 reference, bit 5 left-align. Reads return the last value written.
- Address 2, result (read only).
- Address 3 reads as 0.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After synchronous reset, every control bit, the selection register, the result, `chan_sel`, `ref_sel` and `irq` are 0.
- R2: Writing control with bit 0 and bit 1 set while idle starts a conversion that completes on the 13th tick after the write. At completion the flag (control bit 3) sets, the result is stored, and in single mode the start bit reads back 0.
- R3: The sample input is captured on the 2nd tick of a conversion. Later changes of the input do not alter that conversion's result.
- R4: With control bit 2 set, one start launches back-to-back conversions. The start bit stays 1, and every completion stores a new result.
- R5: Writing 0 to the start bit, with enable kept at 1, has no effect on a running conversion.
- R6: Writing control with bit 0 clear aborts a running conversion at once. Start reads 0, no flag is set and the result keeps its old value.
- R7: A start request written with bit 0 clear starts nothing, and start reads back 0.
- R8: A selection write while idle drives `chan_sel`/`ref_sel` at once. A write during a conversion leaves them unchanged until that conversion completes, and they take the new value in the same cycle as the flag.
- R9: The first conversion that starts after the applied reference changes takes 25 ticks. Later conversions take 13.
- R10: The result reads as {6'b0, r[9:0]} when bit 5 of selection is 0 and as {r[9:0], 6'b0} when it is 1. A change of bit 5 acts immediately, even during a conversion.
- R11: Writing control bit 3 as 1 clears the flag, and `irq` is the flag ANDed with control bit 4.
- R12: Clearing control bit 2 during free-running operation lets the running conversion finish. The start bit then returns to 0 and no further conversion begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| adc_tick | input | 1 | Converter clock-enable, one cycle per conversion step |
| sample_in | input | 10 | Digital word from the converter core |
| chan_sel | output | 3 | Applied input channel |
| ref_sel | output | 2 | Applied reference selection |
| irq | output | 1 | Completion interrupt |

## Verification
Single conversions run with random samples, random channels and random alignment, so every bit of the result and both placements are exercised. A directed pair of samples changes the input after the 2nd tick; this separates a capture on the wrong step from a correct one. Tick counts measured from the start write tell 13-tick conversions from 25-tick ones, and selection writes made in the middle of a conversion show whether changes are staged or applied at once. Abort, disabled start, zero-start and free-running sequences show whether the flag and the start bit follow the control writes or the counter.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

    localparam int RES_W    = 10;
    localparam int DATA_W   = 16;
    localparam int CH_W     = 3;
    localparam int REF_W    = 2;
    localparam int ADDR_W   = 2;
    localparam int REG_W    = 6;
    localparam int NORM_CYC = 13;
    localparam int LONG_CYC = 25;
    localparam int CAP_CYC  = 2;
    localparam int PAD_W    = DATA_W - RES_W;

    // control register bit positions
    localparam int B_EN   = 0;
    localparam int B_GO   = 1;
    localparam int B_FREE = 2;
    localparam int B_FLAG = 3;
    localparam int B_IE   = 4;
    // selection register: channel and reference below, alignment above
    localparam int B_LEFT = CH_W + REF_W;

    typedef struct packed {
        logic [REF_W-1:0] refs;
        logic [CH_W-1:0]  chan;
    } mux_sel_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } conv_phase_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_SEL  = 2'd1,
        RA_DATA = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    function automatic logic [DATA_W-1:0] present_result(
        input logic [RES_W-1:0] r,
        input logic             left
    );
        if (left) return {r, {PAD_W{1'b0}}};
        else      return {{PAD_W{1'b0}}, r};
    endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_conv_pkg::*;
#(
    parameter int SHORT_LEN = NORM_CYC,
    parameter int LONG_LEN  = LONG_CYC,
    parameter int CAP_AT    = CAP_CYC
)(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic abort,
    input  logic restart,
    input  logic tick,
    input  logic long_req,
    output logic busy,
    output logic capture,
    output logic done
);
    localparam int CW = $clog2(LONG_LEN);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] CAP_IDX    = CW'(CAP_AT - 1);

    conv_phase_e   phase;
    logic [CW-1:0] cnt;
    logic          long_q;
    logic [CW-1:0] last;

    assign last    = long_q ? LONG_LAST : SHORT_LAST;
    assign busy    = (phase == PH_RUN);
    assign done    = busy && tick && (cnt == last) && !abort;
    assign capture = busy && tick && (cnt == CAP_IDX) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (abort) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!busy) begin
            if (go) begin
                phase  <= PH_RUN;
                cnt    <= '0;
                long_q <= long_req;
            end
        end else if (tick) begin
            if (cnt == last) begin
                cnt <= '0;
                if (restart) long_q <= long_req;
                else         phase  <= PH_IDLE;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    a_r6_abort_idles: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy);
    a_r9_count_in_window: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LONG_LAST));
    a_r4_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (done && restart) |=> (busy && cnt == '0));

endmodule

// File: rtl/adc_sel_stage.sv
module adc_sel_stage
    import adc_conv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_sel,
    input  mux_sel_t wr_val,
    input  logic     busy,
    input  logic     done,
    input  logic     launch,
    output mux_sel_t applied,
    output logic     long_req
);
    mux_sel_t pend;
    logic     pend_v;
    logic     long_pend;
    logic     window_open;
    logic     apply_v;
    mux_sel_t apply_val;
    logic     ref_chg;

    assign window_open = !busy || done;
    assign apply_v     = window_open && (wr_sel || pend_v);
    assign apply_val   = wr_sel ? wr_val : pend;
    assign ref_chg     = apply_v && (apply_val.refs != applied.refs);
    assign long_req    = long_pend || ref_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            applied   <= '0;
            pend      <= '0;
            pend_v    <= 1'b0;
            long_pend <= 1'b0;
        end else begin
            if (apply_v) applied <= apply_val;
            if (wr_sel && !window_open) begin
                pend   <= wr_val;
                pend_v <= 1'b1;
            end else if (window_open) begin
                pend_v <= 1'b0;
            end
            long_pend <= launch ? 1'b0 : long_req;
        end
    end

    a_r8_hold_while_running: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(applied));
    a_r8_apply_at_done: assert property (@(posedge clk) disable iff (rst)
        (done && pend_v && !wr_sel) |=> (applied == $past(pend)));

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [RES_W-1:0]  sample,
    input  logic              done,
    input  logic              left,
    output logic [DATA_W-1:0] data
);
    logic [RES_W-1:0] samp_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            res_q  <= '0;
        end else begin
            if (capture) samp_q <= sample;
            if (done)    res_q  <= samp_q;
        end
    end

    assign data = present_result(res_q, left);

    a_r3_capture_sample: assert property (@(posedge clk) disable iff (rst)
        capture |=> (samp_q == $past(sample)));
    a_r6_result_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(res_q));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              adc_tick,
    input  logic [RES_W-1:0]  sample_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic [REF_W-1:0]  ref_sel,
    output logic              irq
);
    logic     en_q, start_q, free_q, flag_q, ie_q, left_q;
    mux_sel_t sel_req_q;
    mux_sel_t wr_val;
    mux_sel_t applied;
    logic     wr_ctrl, wr_sel;
    logic     go, abort, launch;
    logic     busy, capture, done, long_req;
    logic [DATA_W-1:0] result;

    assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
    assign wr_sel  = wr_en && (reg_addr_e'(wr_addr) == RA_SEL);
    assign wr_val  = mux_sel_t'(wr_data[CH_W+REF_W-1:0]);
    assign go      = wr_ctrl && wr_data[B_EN] && wr_data[B_GO] && !busy;
    assign abort   = wr_ctrl && !wr_data[B_EN];
    assign launch  = go || (done && free_q);

    adc_conv_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .abort    (abort),
        .restart  (free_q),
        .tick     (adc_tick),
        .long_req (long_req),
        .busy     (busy),
        .capture  (capture),
        .done     (done)
    );

    adc_sel_stage u_sel (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wr_val   (wr_val),
        .busy     (busy),
        .done     (done),
        .launch   (launch),
        .applied  (applied),
        .long_req (long_req)
    );

    adc_result_reg u_res (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .sample  (sample_in),
        .done    (done),
        .left    (left_q),
        .data    (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            start_q   <= 1'b0;
            free_q    <= 1'b0;
            flag_q    <= 1'b0;
            ie_q      <= 1'b0;
            left_q    <= 1'b0;
            sel_req_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= wr_data[B_EN];
                free_q <= wr_data[B_FREE];
                ie_q   <= wr_data[B_IE];
            end
            if (abort)                start_q <= 1'b0;
            else if (go)              start_q <= 1'b1;
            else if (done && !free_q) start_q <= 1'b0;

            if (done)                             flag_q <= 1'b1;
            else if (wr_ctrl && wr_data[B_FLAG])  flag_q <= 1'b0;

            if (wr_sel) begin
                sel_req_q <= wr_val;
                left_q    <= wr_data[B_LEFT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_CTRL: rd_data = {{(DATA_W-5){1'b0}}, ie_q, flag_q, free_q, start_q, en_q};
            RA_SEL:  rd_data = {{(DATA_W-REG_W){1'b0}}, left_q, sel_req_q};
            RA_DATA: rd_data = result;
            default: rd_data = '0;
        endcase
    end

    assign chan_sel = applied.chan;
    assign ref_sel  = applied.refs;
    assign irq      = flag_q && ie_q;

    a_r7_no_start_when_off: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_data[B_EN]) |=> (!start_q && !busy));
    a_r5_zero_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data[B_EN] && !wr_data[B_GO] && start_q && !done) |=> start_q);
    a_r2_single_finish: assert property (@(posedge clk) disable iff (rst)
        (done && !free_q) |=> (!start_q && flag_q && !busy));
    a_r4_free_keeps_start: assert property (@(posedge clk) disable iff (rst)
        (done && free_q) |=> (start_q && busy));
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_data[B_FLAG] && !done) |=> !flag_q);

endmodule

// File: tb/adc_conv_ctrl_tb_top.sv
module adc_conv_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [5:0]  wr_data;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        adc_tick;
    logic [9:0]  sample_in;
    logic [2:0]  chan_sel;
    logic [1:0]  ref_sel;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int tick_total = 0;
    int t_start = 0;

    always #10 clk = ~clk;

    adc_conv_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .adc_tick  (adc_tick),
        .sample_in (sample_in),
        .chan_sel  (chan_sel),
        .ref_sel   (ref_sel),
        .irq       (irq)
    );

    // one tick every third clock
    initial begin
        int ph;
        ph = 0;
        adc_tick = 1'b0;
        forever begin
            @(negedge clk);
            adc_tick = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    always @(posedge clk) if (adc_tick) tick_total <= tick_total + 1;

    function automatic logic [15:0] exp_data(input logic [9:0] s, input logic left);
        return left ? {s, 6'b0} : {6'b0, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic start(input logic [5:0] ctrl);
        wr(2'd0, ctrl);
        t_start = tick_total;
    endtask

    task automatic wait_ticks(input int n);
        int t;
        t = tick_total;
        while (tick_total - t < n) @(negedge clk);
    endtask

    task automatic wait_flag(output int ticks);
        logic [15:0] v;
        bit found;
        found = 1'b0;
        ticks = -1;
        for (int i = 0; i < 400 && !found; i++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (v[3]) begin
                found = 1'b1;
                ticks = tick_total - t_start;
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int tk;
        logic [9:0] s;
        logic l;
        logic [2:0] ch;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; sample_in = '0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
        rd(2'd1, v); chk("R1 sel", v, 16'h0);
        rd(2'd2, v); chk("R1 data", v, 16'h0);
        chk("R1 outputs", {irq, chan_sel, ref_sel}, 6'h0);

        // R7 start with enable clear
        wr(2'd0, 6'h02);
        rd(2'd0, v); chk("R7 start reads 0", v, 16'h0);
        wait_ticks(30);
        rd(2'd0, v); chk("R7 no flag", v, 16'h0);

        // R2 single conversion
        sample_in = 10'h2A5;
        start(6'h0B);
        rd(2'd0, v); chk("R2 start set", v[1], 1'b1);
        wait_flag(tk); chk("R2 tick count", tk, 13);
        rd(2'd0, v); chk("R2 ctrl after done", v, 16'h09);
        rd(2'd2, v); chk("R2 result", v, 16'h02A5);
        chk("R11 irq off when disabled", irq, 1'b0);

        // R3 capture point
        sample_in = 10'h155;
        start(6'h0B);
        wait_ticks(2);
        sample_in = 10'h0AA;
        wait_flag(tk);
        rd(2'd2, v); chk("R3 sample held", v, 16'h0155);

        // R10 alignment
        wr(2'd1, 6'h20);
        rd(2'd2, v); chk("R10 left idle", v, 16'h5540);
        sample_in = 10'h3FF;
        start(6'h0B);
        wait_ticks(4);
        wr(2'd1, 6'h00);
        rd(2'd2, v); chk("R10 right mid-conversion", v, 16'h0155);
        wait_flag(tk);
        rd(2'd2, v); chk("R10 new result right", v, 16'h03FF);

        // R11 interrupt and flag clear
        start(6'h1B);
        wait_flag(tk);
        chk("R11 irq set", irq, 1'b1);
        wr(2'd0, 6'h19);
        chk("R11 irq cleared", irq, 1'b0);
        rd(2'd0, v); chk("R11 ctrl after clear", v, 16'h11);

        // R5 writing 0 to start
        sample_in = 10'h123;
        start(6'h0B);
        wait_ticks(4);
        wr(2'd0, 6'h01);
        rd(2'd0, v); chk("R5 start kept", v[1], 1'b1);
        wait_flag(tk); chk("R5 tick count", tk, 13);
        rd(2'd2, v); chk("R5 result", v, 16'h0123);

        // R6 abort
        sample_in = 10'h111;
        start(6'h0B);
        wait_ticks(5);
        wr(2'd0, 6'h00);
        rd(2'd0, v); chk("R6 ctrl after abort", v, 16'h0);
        wait_ticks(30);
        rd(2'd0, v); chk("R6 no flag", v, 16'h0);
        rd(2'd2, v); chk("R6 result kept", v, 16'h0123);

        // R8/R9 idle selection write and long conversion
        wr(2'd1, 6'h13);
        chk("R8 idle apply", {chan_sel, ref_sel}, {3'd3, 2'd2});
        start(6'h0B);
        wait_flag(tk); chk("R9 long after ref change", tk, 25);
        start(6'h0B);
        wait_flag(tk); chk("R9 short afterwards", tk, 13);

        // R8 staged write
        start(6'h0B);
        wait_ticks(3);
        wr(2'd1, 6'h0D);
        chk("R8 held during conversion", {chan_sel, ref_sel}, {3'd3, 2'd2});
        rd(2'd1, v); chk("R8 sel readback", v, 16'h0D);
        wait_flag(tk); chk("R8 staged conv length", tk, 13);
        chk("R8 applied at done", {chan_sel, ref_sel}, {3'd5, 2'd1});
        start(6'h0B);
        wait_flag(tk); chk("R9 long after staged ref", tk, 25);

        // R4 free-running
        sample_in = 10'h0F0;
        start(6'h0F);
        wait_flag(tk); chk("R4 first length", tk, 13);
        rd(2'd0, v); chk("R4 start stays", v[1], 1'b1);
        rd(2'd2, v); chk("R4 first result", v, 16'h00F0);
        sample_in = 10'h30C;
        wr(2'd0, 6'h0F);
        wait_flag(tk);
        rd(2'd2, v); chk("R4 repeat result", v, 16'h030C);

        // R12 leaving free-running
        wr(2'd0, 6'h09);
        rd(2'd0, v); chk("R12 start until done", v[1], 1'b1);
        wait_flag(tk);
        rd(2'd0, v); chk("R12 ctrl after last", v, 16'h09);
        wr(2'd0, 6'h09);
        wait_ticks(40);
        rd(2'd0, v); chk("R12 no further conversion", v, 16'h01);

        // random single conversions (R2, R10, R8)
        for (int i = 0; i < 24; i++) begin
            s  = 10'($urandom);
            l  = 1'($urandom);
            ch = 3'($urandom);
            wr(2'd1, {l, 2'd1, ch});
            chk("R8 random idle channel", chan_sel, ch);
            sample_in = s;
            start(6'h0B);
            wait_flag(tk); chk("R2 random length", tk, 13);
            rd(2'd2, v); chk("R10 random result", v, exp_data(s, l));
        end

        finish_run();
    end

endmodule